// File: doc/BRIEF.md
# I2C Master Arbitration Monitor

This block runs alongside the bit engine of an I2C master and watches for the moment another master takes the bus. It synchronises the raw SDA and SCL pins. On every rising edge of the synchronised SCL, it compares the level the master meant to leave on SDA with the level actually on the wire. A bit that the master left released (high) but that reads low means another device has won the bus. The block then raises a sticky lost flag. It also sends the sequencer a one-cycle request to fall back to slave-receiver behaviour.

The comparison happens only in the slots where a loss can occur. In transmit mode these are the eight data bits. In receive mode it is only the acknowledge slot, and only when the master sends a not-acknowledge. A clock-continue enable tells the clock generator whether to keep producing SCL pulses. After a loss during a transmitted data bit, the enable stays high until the rest of the byte has been clocked. After a loss at the last data bit or in the acknowledge slot, it drops at once. The lost flag clears on an explicit clear pulse or when a START or STOP condition is seen on the bus.

Top module: `i2c_arb_monitor`

## Requirements
- R1: While and right after reset, `arb_lost` and `switch_req` are 0.
- R2: In transmit mode (`rx_mode`=0), a data slot (`bit_idx` 0 to 7) where `drv_sda`=1 but SDA is sampled 0 at an SCL rising edge sets `arb_lost`. The flag is visible 3 clock cycles after the SCL pin rises.
- R3: Slots where `drv_sda`=0 are never compared. In transmit mode, the acknowledge slot (`bit_idx`=8) and indices 9 to 15 are never compared.
- R4: In receive mode (`rx_mode`=1), only `bit_idx`=8 with `drv_sda`=1 (not-acknowledge) is compared, and a low there sets `arb_lost`. Data slots are ignored.
- R5: `switch_req` is a one-cycle pulse in the same cycle that `arb_lost` rises. No further pulse occurs while `arb_lost` stays set.
- R6: After a transmit loss at data index k below 7, `clk_run` stays 1 for the next 7-k SCL rising edges. It goes to 0 once the rising edge of index 7 has been seen.
- R7: After a loss at data index 7 in transmit mode, or in the acknowledge slot in receive mode, `clk_run` is 0 from the cycle in which `arb_lost` rises.
- R8: `arb_lost` is sticky. It clears one cycle after a `clr_lost` pulse, and it clears after a START (SDA falls while SCL high) or a STOP (SDA rises while SCL high) is seen on the bus.
- R9: With `master_active`=0, no comparison takes place and, while not lost, `clk_run` is 0.
- R10: While `arb_lost` is 0, `clk_run` equals `master_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_pin | input | 1 | Raw SDA level from the bus |
| scl_pin | input | 1 | Raw SCL level from the bus |
| master_active | input | 1 | The controller currently acts as bus master |
| rx_mode | input | 1 | 0 = master transmit, 1 = master receive |
| drv_sda | input | 1 | Level the master intends on SDA in this slot (1 = released) |
| bit_idx | input | IDX_W | Slot within the byte: 0 to 7 data, 8 acknowledge |
| clr_lost | input | 1 | Clears the lost flag and the remaining-clock count |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| switch_req | output | 1 | One-cycle request to fall back to slave receiver |
| clk_run | output | 1 | Enable for the SCL clock generator |

## Verification
The pin path has two synchroniser stages followed by one result register. A change on `scl_pin` or `sda_pin` therefore reaches `arb_lost`, `switch_req` and the count behind `clk_run` on the third rising clock edge. `clr_lost` acts on the first edge. The bench drives pins on falling edges and holds each SCL phase for at least four cycles. It samples results on the fifth falling edge after the SCL pin rises, which is past the due cycle. `switch_req` is counted as high cycles on falling edges over each bit window, so a single pulse reads as exactly one.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

  // True when a slot takes part in the arbitration comparison.
  function automatic logic slot_checked(input logic rx, input int unsigned idx,
                                        input int unsigned data_bits);
    if (rx) return (idx == data_bits);
    return (idx < data_bits);
  endfunction

  // SCL rising edges still to be generated after a loss in the given slot.
  function automatic int unsigned bits_left(input logic rx, input int unsigned idx,
                                            input int unsigned data_bits);
    if (rx) return 0;
    if (idx >= data_bits - 1) return 0;
    return data_bits - 1 - idx;
  endfunction

endpackage

// File: rtl/i2c_arb_sync.sv
module i2c_arb_sync #(
  parameter int WIDTH     = 2,
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= {WIDTH{RESET_VAL}};
        else        stage_q[s] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= {WIDTH{RESET_VAL}};
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_arb_cond.sv
module i2c_arb_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic start_det,
  output logic stop_det
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_arb_judge.sv
module i2c_arb_judge
  import i2c_arb_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             sda_s,
  input  logic             master_active,
  input  logic             rx_mode,
  input  logic             drv_sda,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             clr_req,
  output logic             mismatch_evt,
  output logic             arb_lost,
  output logic             switch_req
);
  logic in_slot;

  assign in_slot = slot_checked(rx_mode, int'(bit_idx), DATA_BITS);

  // A released bit that reads low on a rising SCL edge means the bus was taken.
  assign mismatch_evt = scl_rise & master_active & ~arb_lost & in_slot
                      & drv_sda & ~sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_lost   <= 1'b0;
      switch_req <= 1'b0;
    end else begin
      switch_req <= mismatch_evt;
      if (mismatch_evt)  arb_lost <= 1'b1;
      else if (clr_req)  arb_lost <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_arb_clkctl.sv
module i2c_arb_clkctl
  import i2c_arb_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mismatch_evt,
  input  logic             rx_mode,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             scl_rise,
  input  logic             clr_req,
  input  logic             arb_lost,
  input  logic             master_active,
  output logic             remain_nz,
  output logic             clk_run
);
  localparam int CNT_W = $clog2(DATA_BITS + 1);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (mismatch_evt) begin
      remain_q <= CNT_W'(bits_left(rx_mode, int'(bit_idx), DATA_BITS));
    end else if (clr_req) begin
      remain_q <= '0;
    end else if (arb_lost && scl_rise && remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign remain_nz = (remain_q != '0);
  assign clk_run   = arb_lost ? remain_nz : master_active;
endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor #(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = $clog2(DATA_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_pin,
  input  logic             scl_pin,
  input  logic             master_active,
  input  logic             rx_mode,
  input  logic             drv_sda,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             clr_lost,
  output logic             arb_lost,
  output logic             switch_req,
  output logic             clk_run
);
  logic [1:0] pins_s;
  logic       scl_s;
  logic       sda_s;
  logic       scl_rise;
  logic       start_det;
  logic       stop_det;
  logic       bus_clear;
  logic       clr_req;
  logic       mismatch_evt;
  logic       remain_nz;

  i2c_arb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({scl_pin, sda_pin}),
    .d_out (pins_s)
  );

  assign scl_s = pins_s[1];
  assign sda_s = pins_s[0];

  i2c_arb_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  assign bus_clear = start_det | stop_det;
  assign clr_req   = clr_lost | bus_clear;

  i2c_arb_judge #(.DATA_BITS(DATA_BITS), .IDX_W(IDX_W)) u_judge (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_rise      (scl_rise),
    .sda_s         (sda_s),
    .master_active (master_active),
    .rx_mode       (rx_mode),
    .drv_sda       (drv_sda),
    .bit_idx       (bit_idx),
    .clr_req       (clr_req),
    .mismatch_evt  (mismatch_evt),
    .arb_lost      (arb_lost),
    .switch_req    (switch_req)
  );

  i2c_arb_clkctl #(.DATA_BITS(DATA_BITS), .IDX_W(IDX_W)) u_clkctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .mismatch_evt  (mismatch_evt),
    .rx_mode       (rx_mode),
    .bit_idx       (bit_idx),
    .scl_rise      (scl_rise),
    .clr_req       (clr_req),
    .arb_lost      (arb_lost),
    .master_active (master_active),
    .remain_nz     (remain_nz),
    .clk_run       (clk_run)
  );
endmodule

// File: rtl/i2c_arb_monitor_chk.sv
module i2c_arb_monitor_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             master_active,
  input logic             clr_lost,
  input logic             drv_sda,
  input logic [IDX_W-1:0] bit_idx,
  input logic             arb_lost,
  input logic             switch_req,
  input logic             clk_run,
  input logic             mismatch_evt,
  input logic             bus_clear,
  input logic             remain_nz
);
  // R2: the flag only rises after a detected mismatch
  a_r2_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> $past(mismatch_evt));

  // R3: a slot the master drives low is never a mismatch
  a_r3_low_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_evt |-> drv_sda);

  // R5: request pulse coincides with the flag rising
  a_r5_pulse_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    switch_req |-> $rose(arb_lost));

  // R5: request lasts one cycle
  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    switch_req |=> !switch_req);

  // R6: clocks continue while bits remain after a loss
  a_r6_keep_clocking: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && remain_nz) |-> clk_run);

  // R7: loss in the acknowledge slot stops clocking at once
  a_r7_ack_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(arb_lost) && $past(bit_idx) == IDX_W'(8)) |-> !clk_run);

  // R8: flag holds unless cleared
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !clr_lost && !bus_clear) |=> arb_lost);

  // R9: an idle, non-lost controller does not clock
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_active && !arb_lost) |-> !clk_run);
endmodule

bind i2c_arb_monitor i2c_arb_monitor_chk #(.IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .master_active (master_active),
  .clr_lost      (clr_lost),
  .drv_sda       (drv_sda),
  .bit_idx       (bit_idx),
  .arb_lost      (arb_lost),
  .switch_req    (switch_req),
  .clk_run       (clk_run),
  .mismatch_evt  (mismatch_evt),
  .bus_clear     (bus_clear),
  .remain_nz     (remain_nz)
);

// File: tb/tb_i2c_arb_monitor.sv
module tb_i2c_arb_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sda_pin = 1'b1;
  logic       scl_pin = 1'b1;
  logic       master_active = 1'b0;
  logic       rx_mode = 1'b0;
  logic       drv_sda = 1'b0;
  logic [3:0] bit_idx = 4'd0;
  logic       clr_lost = 1'b0;
  logic       arb_lost;
  logic       switch_req;
  logic       clk_run;

  int total = 0;
  int bad = 0;
  int pulses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_arb_monitor dut (
    .clk(clk), .rst_n(rst_n), .sda_pin(sda_pin), .scl_pin(scl_pin),
    .master_active(master_active), .rx_mode(rx_mode), .drv_sda(drv_sda),
    .bit_idx(bit_idx), .clr_lost(clr_lost), .arb_lost(arb_lost),
    .switch_req(switch_req), .clk_run(clk_run)
  );

  always @(negedge clk) if (switch_req) pulses++;

  // {rx, idx, drv, bus sda, expected lost, expected run}
  localparam logic [8:0] VECS [NVEC] = '{
    {1'b0, 4'd3,  1'b1, 1'b0, 1'b1, 1'b1},  // R2 loss mid byte
    {1'b0, 4'd0,  1'b1, 1'b0, 1'b1, 1'b1},  // R2 loss first bit
    {1'b0, 4'd3,  1'b1, 1'b1, 1'b0, 1'b1},  // R2 match
    {1'b0, 4'd3,  1'b0, 1'b0, 1'b0, 1'b1},  // R3 driven low
    {1'b0, 4'd8,  1'b1, 1'b0, 1'b0, 1'b1},  // R3 tx ack slot
    {1'b0, 4'd12, 1'b1, 1'b0, 1'b0, 1'b1},  // R3 out of range
    {1'b0, 4'd7,  1'b1, 1'b0, 1'b1, 1'b0},  // R7 last data bit
    {1'b1, 4'd3,  1'b1, 1'b0, 1'b0, 1'b1},  // R4 rx data ignored
    {1'b1, 4'd8,  1'b1, 1'b0, 1'b1, 1'b0},  // R4 R7 nack overruled
    {1'b1, 4'd8,  1'b1, 1'b1, 1'b0, 1'b1},  // R4 nack intact
    {1'b1, 4'd8,  1'b0, 1'b0, 1'b0, 1'b1},  // R4 ack driven low
    {1'b0, 4'd6,  1'b1, 1'b0, 1'b1, 1'b1}   // R6 one bit left
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic scl_low();
    @(negedge clk) scl_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_bit(input logic rx, input logic [3:0] idx,
                        input logic drv, input logic sda);
    scl_low();
    sda_pin = sda; rx_mode = rx; bit_idx = idx; drv_sda = drv;
    repeat (4) @(negedge clk);
    scl_pin = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic do_clear();
    scl_low();
    clr_lost = 1'b1;
    @(negedge clk) clr_lost = 1'b0;
    repeat (2) @(negedge clk);
    pulses = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 lost in reset", arb_lost, 0);
    check("R1 req in reset", switch_req, 0);
    check("R9 run idle", clk_run, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 lost after reset", arb_lost, 0);
    master_active = 1'b1;
    @(negedge clk);
    check("R10 run follows active", clk_run, 1);

    for (int i = 0; i < NVEC; i++) begin
      do_clear();
      do_bit(VECS[i][8], VECS[i][7:4], VECS[i][3], VECS[i][2]);
      check($sformatf("R2 R3 R4 lost vec%0d", i), arb_lost, VECS[i][1]);
      check($sformatf("R6 R7 R10 run vec%0d", i), clk_run, VECS[i][0]);
      check($sformatf("R5 pulses vec%0d", i), pulses, VECS[i][1]);
    end

    // R6: loss at index 5 keeps clocking through index 7
    do_clear();
    do_bit(1'b0, 4'd5, 1'b1, 1'b0);
    check("R6 lost at 5", arb_lost, 1);
    do_bit(1'b0, 4'd6, 1'b1, 1'b1);
    check("R6 run after 6", clk_run, 1);
    do_bit(1'b0, 4'd7, 1'b1, 1'b0);
    check("R6 run after 7", clk_run, 0);
    check("R8 still lost", arb_lost, 1);
    check("R5 no second pulse", pulses, 1);

    // R8: explicit clear
    do_clear();
    check("R8 clr clears", arb_lost, 0);
    check("R10 run after clr", clk_run, 1);

    // R8: START clears
    do_bit(1'b0, 4'd2, 1'b1, 1'b0);
    check("R8 lost before start", arb_lost, 1);
    do_bit(1'b1, 4'd9, 1'b0, 1'b1);
    @(negedge clk) sda_pin = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 start clears", arb_lost, 0);

    // R8: STOP clears
    do_clear();
    do_bit(1'b0, 4'd1, 1'b1, 1'b0);
    check("R8 lost before stop", arb_lost, 1);
    do_bit(1'b1, 4'd9, 1'b0, 1'b0);
    @(negedge clk) sda_pin = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 stop clears", arb_lost, 0);

    // R9: not master, no detection
    master_active = 1'b0;
    do_clear();
    do_bit(1'b0, 4'd3, 1'b1, 1'b0);
    check("R9 no loss when idle", arb_lost, 0);
    check("R9 no run when idle", clk_run, 0);
    check("R9 no pulse when idle", pulses, 0);
    master_active = 1'b1;
    @(negedge clk);
    check("R10 run restored", clk_run, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule